// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading translation descriptors from memory. A one-cycle start pulse presents the virtual address, the translation table base and a flag that says whether fine tables and tiny pages are supported. The walker reads one first-level descriptor and, if that descriptor points to a second-level table, one second-level descriptor. It then reports the physical address, the page kind, the cacheable/bufferable pair, the domain and the access-permission bits, or a fault.

Memory is reached through a plain word-read port. The walker raises a request with an address and holds both until the memory accepts them. The memory then returns one data word with a valid strobe, no earlier than the cycle after acceptance. Only one read is in flight at a time. The walker keeps no record of earlier translations. Every start costs a full walk.

The reset input is asynchronous and active low. The surrounding logic is expected to release it in step with the clock.

Top module: `ptw_walker`

## Requirements
- R1: The first-level read address is {base[31:14], va[31:20], 2'b00}. Base bits [13:0] have no effect.
- R2: A first-level descriptor whose bits [1:0] are 00 ends the walk with fault = 1 after that single read. On any fault, pa, page_type, cb, domain and ap all read zero.
- R3: When tiny_en = 0, a first-level descriptor with bits [1:0] = 11 ends the walk as a fault after that single read.
- R4: A first-level descriptor with bits [1:0] = 10 is a section, page_type = 0. Only one read is made, and pa = {desc[31:20], va[19:0]}, cb = desc[3:2], ap = {6'b0, desc[11:10]}.
- R5: A first-level descriptor with bits [1:0] = 01 selects a coarse table. The second read address is {desc[31:10], va[19:12], 2'b00}.
- R6: A first-level descriptor with bits [1:0] = 11 and tiny_en = 1 selects a fine table. The second read address is {desc[31:12], va[19:10], 2'b00}.
- R7: A second-level descriptor with bits [1:0] = 00 ends the walk with fault = 1 after two reads.
- R8: A second-level code of 01 is a large page, page_type = 1. Then pa = {desc[31:16], va[15:0]}, ap = desc[11:4], cb = desc[3:2].
- R9: A second-level code of 10 is a small page, page_type = 2. Then pa = {desc[31:12], va[11:0]}, ap = desc[11:4], cb = desc[3:2].
- R10: A second-level code of 11 is a tiny page, page_type = 3. Then pa = {desc[31:10], va[9:0]}, ap = {6'b0, desc[5:4]}, cb = desc[3:2].
- R11: On every successful walk, domain equals first-level descriptor bits [8:5].
- R12: mem_req stays high with mem_addr stable until mem_gnt. No new request is raised while a read is still awaiting mem_rvalid.
- R13: done is high for exactly one cycle per walk. busy rises the cycle after an accepted start and stays high through the done cycle. A start while busy is ignored.
- R14: While rst_n is low, busy, done, mem_req and fault are 0 and pa is zero, even in the middle of a walk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| va | input | 32 | Virtual address to translate |
| ttb | input | 32 | Translation table base |
| tiny_en | input | 1 | 1 = fine tables and tiny pages supported |
| busy | output | 1 | Walk in progress, including the done cycle |
| mem_req | output | 1 | Read request |
| mem_addr | output | 32 | Word address of the read |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data (descriptor) |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a translation fault |
| pa | output | 32 | Physical address |
| page_type | output | 2 | 0 section, 1 large, 2 small, 3 tiny |
| cb | output | 2 | Cacheable/bufferable bits |
| domain | output | 4 | Domain number |
| ap | output | 8 | Access-permission bits |

## Verification
Most faults inside the walker show up on the memory port before any result appears. A wrong state or a wrong latched base or address changes the second request address, or the number of reads, within a cycle or two of the first acceptance. A wrongly decoded descriptor code shows up at the single done pulse as the wrong page_type, a fault that should not be there, or a pa whose pass-through low bits are not the virtual offset. A state machine that stalls or repeats shows up as a missing or doubled done pulse, or as busy that never drops.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  localparam int ADDR_W = 32;
  localparam int CB_W   = 2;
  localparam int DOM_W  = 4;
  localparam int AP_W   = 8;

  // descriptor low-bit codes; the decode depends on these values
  localparam logic [1:0] L1_FAULT   = 2'b00;
  localparam logic [1:0] L1_COARSE  = 2'b01;
  localparam logic [1:0] L1_SECTION = 2'b10;
  localparam logic [1:0] L1_FINE    = 2'b11;

  localparam logic [1:0] L2_FAULT = 2'b00;
  localparam logic [1:0] L2_LARGE = 2'b01;
  localparam logic [1:0] L2_SMALL = 2'b10;
  localparam logic [1:0] L2_TINY  = 2'b11;

  typedef enum logic [1:0] {
    PG_SECTION = 2'd0,
    PG_LARGE   = 2'd1,
    PG_SMALL   = 2'd2,
    PG_TINY    = 2'd3
  } page_kind_e;

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_FETCH_L1 = 3'd1,
    S_WAIT_L1  = 3'd2,
    S_FETCH_L2 = 3'd3,
    S_WAIT_L2  = 3'd4,
    S_DONE     = 3'd5
  } walk_state_e;

  typedef struct packed {
    logic              fault;
    page_kind_e        kind;
    logic [ADDR_W-1:0] pa;
    logic [CB_W-1:0]   cb;
    logic [DOM_W-1:0]  dom;
    logic [AP_W-1:0]   ap;
  } walk_res_t;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [17:0]       ttb_hi,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] l1_desc,
  output logic [ADDR_W-1:0] l1_addr,
  output logic [ADDR_W-1:0] l2_addr
);

  logic [ADDR_W-1:0] coarse_addr;
  logic [ADDR_W-1:0] fine_addr;
  logic              unused_desc_bits;

  assign l1_addr     = {ttb_hi, va[31:20], 2'b00};
  assign coarse_addr = {l1_desc[31:10], va[19:12], 2'b00};
  assign fine_addr   = {l1_desc[31:12], va[19:10], 2'b00};

  always_comb begin
    if (l1_desc[1:0] == L1_FINE) l2_addr = fine_addr;
    else                         l2_addr = coarse_addr;
  end

  assign unused_desc_bits = ^l1_desc[9:2];

endmodule

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [19:0]       va_off,
  output logic              is_fault,
  output logic              is_section,
  output logic              is_fine,
  output logic [ADDR_W-1:0] sec_pa,
  output logic [CB_W-1:0]   sec_cb,
  output logic [1:0]        sec_ap,
  output logic [DOM_W-1:0]  dom
);

  logic unused_desc_bits;

  assign is_fault   = (desc[1:0] == L1_FAULT);
  assign is_section = (desc[1:0] == L1_SECTION);
  assign is_fine    = (desc[1:0] == L1_FINE);
  assign sec_pa     = {desc[31:20], va_off};
  assign sec_cb     = desc[3:2];
  assign sec_ap     = desc[11:10];
  assign dom        = desc[8:5];

  assign unused_desc_bits = ^{desc[19:12], desc[9], desc[4]};

endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
  import ptw_pkg::*;
(
  input  logic [ADDR_W-1:0] desc,
  input  logic [15:0]       va_off,
  output logic              is_fault,
  output page_kind_e        kind,
  output logic [ADDR_W-1:0] pa,
  output logic [CB_W-1:0]   cb,
  output logic [AP_W-1:0]   ap
);

  assign is_fault = (desc[1:0] == L2_FAULT);
  assign cb       = desc[3:2];

  always_comb begin
    case (desc[1:0])
      L2_LARGE: begin
        kind = PG_LARGE;
        pa   = {desc[31:16], va_off};
        ap   = desc[11:4];
      end
      L2_SMALL: begin
        kind = PG_SMALL;
        pa   = {desc[31:12], va_off[11:0]};
        ap   = desc[11:4];
      end
      L2_TINY: begin
        kind = PG_TINY;
        pa   = {desc[31:10], va_off[9:0]};
        ap   = {6'b0, desc[5:4]};
      end
      default: begin
        kind = PG_SECTION;
        pa   = '0;
        ap   = '0;
      end
    endcase
  end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] va,
  input  logic [ADDR_W-1:0] ttb,
  input  logic              tiny_en,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [ADDR_W-1:0] pa,
  output logic [1:0]        page_type,
  output logic [CB_W-1:0]   cb,
  output logic [DOM_W-1:0]  domain,
  output logic [AP_W-1:0]   ap
);

  walk_state_e       state_q, state_d;
  logic [ADDR_W-1:0] va_q;
  logic [17:0]       ttb_hi_q;
  logic              tiny_q;
  logic [ADDR_W-1:0] l2_addr_q;
  logic [DOM_W-1:0]  dom_q;
  walk_res_t         res_q, res_d;

  logic load_en, l2_en, res_en;
  logic unused_ttb_bits;

  logic [ADDR_W-1:0] l1_addr_w, l2_addr_w;
  logic              l1_fault, l1_section, l1_fine;
  logic [ADDR_W-1:0] l1_pa;
  logic [CB_W-1:0]   l1_cb;
  logic [1:0]        l1_ap;
  logic [DOM_W-1:0]  l1_dom;
  logic              l2_fault;
  page_kind_e        l2_kind;
  logic [ADDR_W-1:0] l2_pa;
  logic [CB_W-1:0]   l2_cb;
  logic [AP_W-1:0]   l2_ap;

  ptw_addr_gen u_addr (
    .ttb_hi  (ttb_hi_q),
    .va      (va_q),
    .l1_desc (mem_rdata),
    .l1_addr (l1_addr_w),
    .l2_addr (l2_addr_w)
  );

  ptw_l1_decode u_l1 (
    .desc       (mem_rdata),
    .va_off     (va_q[19:0]),
    .is_fault   (l1_fault),
    .is_section (l1_section),
    .is_fine    (l1_fine),
    .sec_pa     (l1_pa),
    .sec_cb     (l1_cb),
    .sec_ap     (l1_ap),
    .dom        (l1_dom)
  );

  ptw_l2_decode u_l2 (
    .desc     (mem_rdata),
    .va_off   (va_q[15:0]),
    .is_fault (l2_fault),
    .kind     (l2_kind),
    .pa       (l2_pa),
    .cb       (l2_cb),
    .ap       (l2_ap)
  );

  // next-state and result selection
  always_comb begin
    state_d = state_q;
    res_d   = res_q;
    load_en = 1'b0;
    l2_en   = 1'b0;
    res_en  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          load_en = 1'b1;
          state_d = S_FETCH_L1;
        end
      end
      S_FETCH_L1: if (mem_gnt) state_d = S_WAIT_L1;
      S_WAIT_L1: begin
        if (mem_rvalid) begin
          if (l1_fault || (l1_fine && !tiny_q)) begin
            res_d       = '0;
            res_d.fault = 1'b1;
            res_en      = 1'b1;
            state_d     = S_DONE;
          end else if (l1_section) begin
            res_d.fault = 1'b0;
            res_d.kind  = PG_SECTION;
            res_d.pa    = l1_pa;
            res_d.cb    = l1_cb;
            res_d.dom   = l1_dom;
            res_d.ap    = {{(AP_W-2){1'b0}}, l1_ap};
            res_en      = 1'b1;
            state_d     = S_DONE;
          end else begin
            l2_en   = 1'b1;
            state_d = S_FETCH_L2;
          end
        end
      end
      S_FETCH_L2: if (mem_gnt) state_d = S_WAIT_L2;
      S_WAIT_L2: begin
        if (mem_rvalid) begin
          res_en  = 1'b1;
          state_d = S_DONE;
          if (l2_fault) begin
            res_d       = '0;
            res_d.fault = 1'b1;
          end else begin
            res_d.fault = 1'b0;
            res_d.kind  = l2_kind;
            res_d.pa    = l2_pa;
            res_d.cb    = l2_cb;
            res_d.dom   = dom_q;
            res_d.ap    = l2_ap;
          end
        end
      end
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q     <= '0;
      ttb_hi_q <= '0;
      tiny_q   <= 1'b0;
    end else if (load_en) begin
      va_q     <= va;
      ttb_hi_q <= ttb[31:14];
      tiny_q   <= tiny_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      l2_addr_q <= '0;
      dom_q     <= '0;
    end else if (l2_en) begin
      l2_addr_q <= l2_addr_w;
      dom_q     <= l1_dom;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      res_q <= '0;
    else if (res_en) res_q <= res_d;
  end

  assign unused_ttb_bits = ^ttb[13:0];

  assign busy      = (state_q != S_IDLE);
  assign done      = (state_q == S_DONE);
  assign mem_req   = (state_q == S_FETCH_L1) || (state_q == S_FETCH_L2);
  assign mem_addr  = (state_q == S_FETCH_L2) ? l2_addr_q : l1_addr_w;
  assign fault     = res_q.fault;
  assign pa        = res_q.pa;
  assign page_type = res_q.kind;
  assign cb        = res_q.cb;
  assign domain    = res_q.dom;
  assign ap        = res_q.ap;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [31:0] va,
  input logic        busy,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_gnt,
  input logic        mem_rvalid,
  input logic        done,
  input logic        fault,
  input logic [31:0] pa,
  input logic [1:0]  page_type,
  input logic [7:0]  ap
);

  logic [31:0] va_seen;
  logic        pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_seen <= '0;
      pending <= 1'b0;
    end else begin
      if (start && !busy) va_seen <= va;
      if (mem_req && mem_gnt) pending <= 1'b1;
      else if (mem_rvalid)    pending <= 1'b0;
    end
  end

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr));

  assert_one_outstanding_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !mem_req);

  assert_done_pulse_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_in_busy_R13: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_busy_until_done_R13: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !done |=> busy);

  assert_start_takes_R13: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy);

  assert_fault_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done && fault |-> (pa == 32'd0) && (ap == 8'd0) && (page_type == 2'd0));

  assert_section_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && page_type == 2'd0 |-> pa[19:0] == va_seen[19:0]);

  assert_large_offset_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && page_type == 2'd1 |-> pa[15:0] == va_seen[15:0]);

  assert_small_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && page_type == 2'd2 |-> pa[11:0] == va_seen[11:0]);

  assert_tiny_offset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done && !fault && page_type == 2'd3 |-> pa[9:0] == va_seen[9:0] && ap[7:2] == 6'd0);

endmodule

bind ptw_walker ptw_walker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .va         (va),
  .busy       (busy),
  .mem_req    (mem_req),
  .mem_addr   (mem_addr),
  .mem_gnt    (mem_gnt),
  .mem_rvalid (mem_rvalid),
  .done       (done),
  .fault      (fault),
  .pa         (pa),
  .page_type  (page_type),
  .ap         (ap)
);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;

  typedef struct packed {
    logic [31:0] va;
    logic [31:0] ttb;
    logic [31:0] d1;
    logic [31:0] d2;
    logic [31:0] l1a;
    logic [31:0] l2a;
    logic        tiny;
    logic [1:0]  stall;
    logic [1:0]  reads;
    logic        fault;
    logic [31:0] pa;
    logic [1:0]  kind;
    logic [1:0]  cb;
    logic [3:0]  dom;
    logic [7:0]  ap;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h8765_4321, 32'h1234_5678, 32'hABC0_0D4A, 32'h0, 32'h1234_61D8, 32'hFFFF_FFFF, 1'b1, 2'd0, 2'd1, 1'b0, 32'hABC5_4321, 2'd0, 2'd2, 4'hA, 8'h03},
    '{32'h0010_0000, 32'h0000_8000, 32'hFFFF_FFFC, 32'h0, 32'h0000_8004, 32'hFFFF_FFFF, 1'b1, 2'd1, 2'd1, 1'b1, 32'h0, 2'd0, 2'd0, 4'h0, 8'h00},
    '{32'h0020_0000, 32'h0000_8000, 32'h0000_1003, 32'h0, 32'h0000_8008, 32'hFFFF_FFFF, 1'b0, 2'd0, 2'd1, 1'b1, 32'h0, 2'd0, 2'd0, 4'h0, 8'h00},
    '{32'h1234_5678, 32'h0004_0000, 32'h0020_00A1, 32'h9ABC_0E55, 32'h0004_048C, 32'h0020_0114, 1'b1, 2'd2, 2'd2, 1'b0, 32'h9ABC_5678, 2'd1, 2'd1, 4'h5, 8'hE5},
    '{32'hFFF0_3ABC, 32'h0004_0000, 32'h0030_05E1, 32'h5555_53CE, 32'h0004_3FFC, 32'h0030_040C, 1'b1, 2'd1, 2'd2, 1'b0, 32'h5555_5ABC, 2'd2, 2'd3, 4'hF, 8'h3C},
    '{32'h0ABC_DEF0, 32'h0004_0000, 32'h0070_1063, 32'h1357_2DE3, 32'h0004_02AC, 32'h0070_1CDC, 1'b1, 2'd0, 2'd2, 1'b0, 32'h1357_2EF0, 2'd3, 2'd0, 4'h3, 8'h02},
    '{32'h0000_0400, 32'h0004_0000, 32'h0090_20E3, 32'hCAFE_BFFA, 32'h0004_0000, 32'h0090_2004, 1'b1, 2'd2, 2'd2, 1'b0, 32'hCAFE_B400, 2'd2, 2'd2, 4'h7, 8'hFF},
    '{32'h0100_0000, 32'h0004_0000, 32'h00A0_0001, 32'hFFFF_FFF0, 32'h0004_0040, 32'h00A0_0000, 1'b1, 2'd0, 2'd2, 1'b1, 32'h0, 2'd0, 2'd0, 4'h0, 8'h00},
    '{32'h0020_FFFF, 32'h0004_0000, 32'h0011_0123, 32'h7777_0121, 32'h0004_0008, 32'h0011_00FC, 1'b1, 2'd1, 2'd2, 1'b0, 32'h7777_FFFF, 2'd1, 2'd0, 4'h9, 8'h12}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] va, ttb;
  logic        tiny_en;
  logic        busy, mem_req, mem_gnt, mem_rvalid, done, fault;
  logic [31:0] mem_addr, mem_rdata, pa;
  logic [1:0]  page_type, cb;
  logic [3:0]  domain;
  logic [7:0]  ap;

  int   checks = 0;
  int   errors = 0;
  vec_t cur;
  int   reads;
  logic [31:0] rd_addr [2];
  int   stall_left;
  bit   rsp_due;
  logic [31:0] rsp_data;

  always #2.5 clk = ~clk;

  ptw_walker dut (
    .clk(clk), .rst_n(rst_n), .start(start), .va(va), .ttb(ttb), .tiny_en(tiny_en),
    .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .pa(pa), .page_type(page_type), .cb(cb), .domain(domain), .ap(ap)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  function automatic logic [31:0] lookup(input logic [31:0] a);
    if (a == cur.l1a) return cur.d1;
    if (a == cur.l2a) return cur.d2;
    return 32'h0;
  endfunction

  // memory model: grant after cur.stall cycles, data one cycle after grant
  initial begin : mem_model
    mem_gnt = 1'b0; mem_rvalid = 1'b0; mem_rdata = '0;
    rsp_due = 1'b0; stall_left = 0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_gnt = 1'b0; mem_rvalid = 1'b0; rsp_due = 1'b0;
      end else begin
        mem_rvalid = 1'b0;
        if (rsp_due) begin
          mem_rvalid = 1'b1;
          mem_rdata  = rsp_data;
          rsp_due    = 1'b0;
        end
        if (mem_gnt) begin
          mem_gnt = 1'b0;
        end else if (mem_req) begin
          if (stall_left > 0) stall_left--;
          else begin
            mem_gnt = 1'b1;
            if (reads < 2) rd_addr[reads] = mem_addr;
            reads++;
            rsp_data   = lookup(mem_addr);
            rsp_due    = 1'b1;
            stall_left = int'(cur.stall);
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    summary();
    $finish;
  end

  function automatic string tag_of(input int i);
    case (i)
      0: return "R4";  1: return "R2";  2: return "R3";
      3: return "R8";  4: return "R9";  5: return "R10";
      6: return "R6";  7: return "R7";  default: return "R6";
    endcase
  endfunction

  // launch one walk; interfere = hold start high with another address while busy
  task automatic run_vec(input vec_t v, input string tag, input bit interfere);
    int n;
    cur = v; reads = 0; rd_addr[0] = '0; rd_addr[1] = '0;
    stall_left = int'(v.stall);
    @(negedge clk);
    va = v.va; ttb = v.ttb; tiny_en = v.tiny; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R13 busy after start", {31'd0, busy}, 32'd1);
    if (interfere) begin
      va = 32'h8765_4321; ttb = 32'h1234_5678; tiny_en = 1'b0; start = 1'b1;
    end
    n = 0;
    while (done !== 1'b1 && n < 100) begin
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    check(done === 1'b1, {tag, " done reached"}, {31'd0, done}, 32'd1);
    check(rd_addr[0] == v.l1a, "R1 first-level address", rd_addr[0], v.l1a);
    check(reads == int'(v.reads), {tag, " read count"}, reads, {30'd0, v.reads});
    if (v.reads == 2'd2)
      check(rd_addr[1] == v.l2a, (v.d1[1:0] == 2'b01) ? "R5 coarse address" : "R6 fine address",
            rd_addr[1], v.l2a);
    check(fault === v.fault, {tag, " fault"}, {31'd0, fault}, {31'd0, v.fault});
    check(pa === v.pa, {tag, " pa"}, pa, v.pa);
    check(page_type === v.kind, {tag, " page_type"}, {30'd0, page_type}, {30'd0, v.kind});
    check(cb === v.cb, {tag, " cb"}, {30'd0, cb}, {30'd0, v.cb});
    check(domain === v.dom, "R11 domain", {28'd0, domain}, {28'd0, v.dom});
    check(ap === v.ap, {tag, " ap"}, {24'd0, ap}, {24'd0, v.ap});
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R13 done one cycle", {30'd0, done, busy}, 32'd0);
  endtask

  initial begin : stim
    rst_n = 1'b0; start = 1'b0; va = '0; ttb = '0; tiny_en = 1'b1;
    reads = 0; cur = VECS[0];
    repeat (3) @(negedge clk);
    // R14 reset state
    check(busy === 1'b0 && done === 1'b0 && mem_req === 1'b0 && fault === 1'b0,
          "R14 reset outputs", {28'd0, busy, done, mem_req, fault}, 32'd0);
    check(pa === 32'd0, "R14 reset pa", pa, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], tag_of(i), 1'b0);

    // R13: start held while busy is ignored; no second walk follows
    run_vec(VECS[3], "R13 interfered", 1'b1);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(mem_req === 1'b0 && busy === 1'b0, "R13 no walk from start while busy",
            {30'd0, mem_req, busy}, 32'd0);
    end

    // R14: reset in the middle of a walk
    cur = VECS[4]; reads = 0; stall_left = 3;
    va = VECS[4].va; ttb = VECS[4].ttb; tiny_en = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check(mem_req === 1'b1, "R12 request raised", {31'd0, mem_req}, 32'd1);
    rst_n = 1'b0;
    #1;
    check(busy === 1'b0 && mem_req === 1'b0 && done === 1'b0, "R14 mid-walk reset",
          {29'd0, busy, mem_req, done}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R14 idle after reset", {31'd0, busy}, 32'd0);
    run_vec(VECS[6], "R6 after reset", 1'b0);

    summary();
    $finish;
  end

endmodule